// File: doc/BRIEF.md
# Indexed Interrupt Mask Bank

This block holds one mask bit for each of 64 interrupt sources and gates the raw requests with it. A set bit blocks its source. Software can change a single mask bit with one byte-wide command, so no read-modify-write of the whole mask word is needed. A set command masks one source, or every source when its broadcast flag is raised. A clear command uses the same byte layout and unmasks sources. The whole mask word can also be written directly.

The set and clear commands arrive on dedicated write strobes, so both can happen in the same cycle. Firmware reads the mask word and the gated pending vector through a small read port. The command locations on that port always read as zero. The mask word also drives an output that goes straight to the downstream request-gating logic.

Top module: `irq_mask_bank`

## Requirements
- R1: After reset the mask is all ones, the pending output is all zeros, and both command read locations return zero.
- R2: A set command whose bit 6 is 0 sets the one mask bit chosen by bits 5:0 and leaves every other mask bit unchanged.
- R3: A set command whose bit 6 is 1 sets every mask bit, whatever bits 5:0 hold.
- R4: A clear command whose bit 6 is 0 clears the one mask bit chosen by bits 5:0 and leaves every other mask bit unchanged.
- R5: A clear command whose bit 6 is 1 clears every mask bit, whatever bits 5:0 hold.
- R6: If a set command and a clear command hit the same mask bit in the same cycle, that bit ends up set.
- R7: Read address 0 returns the mask word and read address 3 returns the pending vector. Read addresses 1 (set command) and 2 (clear command) always return zero.
- R8: The pending output equals the raw requests ANDed with the inverse of the mask. A mask change shows on the pending output in the cycle after the command edge.
- R9: A full-word write loads the mask. A clear or set command in the same cycle is applied on top of the written word, clear first and then set.
- R10: Bit 7 of a command byte has no effect.
- R11: With no write or command, the mask holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| set_we_i | input | 1 | Set command strobe |
| set_cmd_i | input | 8 | Set command byte: bits 5:0 are the index, bit 6 is all, bit 7 is reserved |
| clr_we_i | input | 1 | Clear command strobe |
| clr_cmd_i | input | 8 | Clear command byte, same layout as the set command byte |
| word_we_i | input | 1 | Full mask word write strobe |
| word_wdata_i | input | 64 | Full mask word write data |
| rd_addr_i | input | 2 | Read select: 0 mask, 1 set command, 2 clear command, 3 pending |
| rd_data_o | output | 64 | Read data, combinational from rd_addr_i |
| irq_req_i | input | 64 | Raw interrupt requests |
| mask_o | output | 64 | Current mask word (1 blocks the source) |
| pend_o | output | 64 | Masked pending vector |

## Verification
The assertions assume that the strobes and command bytes are driven to known values whenever the synchronized reset is released, and that no strobe is raised while the block is held in reset. The bench holds every strobe low through reset and for the synchronizer's release cycles. After that it changes its inputs only on the falling clock edge, so each command lands on a single rising edge. The raw requests are treated as free-running, so the only property the pending checks rely on is that pending never overlaps the mask.

// File: rtl/irqm_pkg.sv
package irqm_pkg;
  localparam int unsigned CMD_W     = 8;
  localparam int unsigned CMD_ALL   = 6;
  localparam int unsigned CMD_IDX_W = 6;

  typedef enum logic [1:0] {
    RD_MASK = 2'd0,
    RD_SET  = 2'd1,
    RD_CLR  = 2'd2,
    RD_PEND = 2'd3
  } rd_sel_e;

  typedef struct packed {
    logic                 hit;
    logic                 all;
    logic [CMD_IDX_W-1:0] idx;
  } cmd_fields_t;

  function automatic cmd_fields_t cmd_split(input logic we, input logic [CMD_W-1:0] cmd);
    cmd_fields_t f;
    f.hit = we;
    f.all = we & cmd[CMD_ALL];
    f.idx = cmd[CMD_IDX_W-1:0];
    return f;
  endfunction
endpackage

// File: rtl/irqm_rst_sync.sv
module irqm_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [1:0] stage_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= {stage_q[0], 1'b1};
    end
  end

  assign rst_sync_no = stage_q[1];
endmodule

// File: rtl/irqm_cmd_decode.sv
module irqm_cmd_decode
  import irqm_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               we_i,
  input  logic [CMD_W-1:0]   cmd_i,
  output logic [NUM_SRC-1:0] hit_o
);
  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  cmd_fields_t fld;
  assign fld = cmd_split(we_i, cmd_i);

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_bit
    logic sel;
    always_comb begin
      sel = (fld.idx[IDX_W-1:0] == IDX_W'(i));
      if (CMD_IDX_W > IDX_W) begin
        sel = sel && (fld.idx >> IDX_W) == '0;
      end
      hit_o[i] = fld.hit & (fld.all | sel);
    end
  end
endmodule

// File: rtl/irqm_mask_reg.sv
module irqm_mask_reg #(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               word_we_i,
  input  logic [NUM_SRC-1:0] word_wdata_i,
  input  logic               any_cmd_i,
  input  logic [NUM_SRC-1:0] set_hit_i,
  input  logic [NUM_SRC-1:0] clr_hit_i,
  output logic [NUM_SRC-1:0] mask_o
);
  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_d;
  logic               mask_en;

  always_comb begin
    mask_en = word_we_i | any_cmd_i;
    mask_d  = word_we_i ? word_wdata_i : mask_q;
    mask_d  = mask_d & ~clr_hit_i;
    mask_d  = mask_d | set_hit_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irqm_read_mux.sv
module irqm_read_mux
  import irqm_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic [1:0]         rd_addr_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic [NUM_SRC-1:0] pend_i,
  output logic [NUM_SRC-1:0] rd_data_o
);
  always_comb begin
    unique case (rd_sel_e'(rd_addr_i))
      RD_MASK: rd_data_o = mask_i;
      RD_PEND: rd_data_o = pend_i;
      default: rd_data_o = '0;
    endcase
  end
endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
  import irqm_pkg::*;
#(
  parameter int unsigned NUM_SRC = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               set_we_i,
  input  logic [CMD_W-1:0]   set_cmd_i,
  input  logic               clr_we_i,
  input  logic [CMD_W-1:0]   clr_cmd_i,
  input  logic               word_we_i,
  input  logic [NUM_SRC-1:0] word_wdata_i,
  input  logic [1:0]         rd_addr_i,
  output logic [NUM_SRC-1:0] rd_data_o,
  input  logic [NUM_SRC-1:0] irq_req_i,
  output logic [NUM_SRC-1:0] mask_o,
  output logic [NUM_SRC-1:0] pend_o
);
  logic               rst_sync_n;
  logic [NUM_SRC-1:0] set_hit;
  logic [NUM_SRC-1:0] clr_hit;
  logic [NUM_SRC-1:0] mask_q;

  irqm_rst_sync u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  irqm_cmd_decode #(.NUM_SRC(NUM_SRC)) u_set_dec (
    .we_i  (set_we_i),
    .cmd_i (set_cmd_i),
    .hit_o (set_hit)
  );

  irqm_cmd_decode #(.NUM_SRC(NUM_SRC)) u_clr_dec (
    .we_i  (clr_we_i),
    .cmd_i (clr_cmd_i),
    .hit_o (clr_hit)
  );

  irqm_mask_reg #(.NUM_SRC(NUM_SRC)) u_mask (
    .clk_i        (clk_i),
    .rst_ni       (rst_sync_n),
    .word_we_i    (word_we_i),
    .word_wdata_i (word_wdata_i),
    .any_cmd_i    (set_we_i | clr_we_i),
    .set_hit_i    (set_hit),
    .clr_hit_i    (clr_hit),
    .mask_o       (mask_q)
  );

  assign mask_o = mask_q;
  assign pend_o = irq_req_i & ~mask_q;

  irqm_read_mux #(.NUM_SRC(NUM_SRC)) u_rd (
    .rd_addr_i (rd_addr_i),
    .mask_i    (mask_q),
    .pend_i    (pend_o),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/irqm_checks.sv
module irqm_checks #(
  parameter int unsigned NUM_SRC = 64
) (
  input logic               clk_i,
  input logic               rst_n,
  input logic               set_we_i,
  input logic [7:0]         set_cmd_i,
  input logic               clr_we_i,
  input logic [7:0]         clr_cmd_i,
  input logic               word_we_i,
  input logic [1:0]         rd_addr_i,
  input logic [NUM_SRC-1:0] rd_data_o,
  input logic [NUM_SRC-1:0] mask_o,
  input logic [NUM_SRC-1:0] pend_o
);
  p_set_all_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    (set_we_i && set_cmd_i[6]) |=> (mask_o == '1));

  p_clr_all_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (clr_we_i && clr_cmd_i[6] && !set_we_i) |=> (mask_o == '0));

  p_set_one_r2: assert property (@(posedge clk_i) disable iff (!rst_n)
    (set_we_i && !set_cmd_i[6] && (32'(set_cmd_i[5:0]) < NUM_SRC))
      |=> mask_o[$past(set_cmd_i[5:0])]);

  p_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!set_we_i && !clr_we_i && !word_we_i) |=> $stable(mask_o));

  p_cmd_read_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_addr_i == 2'd1 || rd_addr_i == 2'd2) |-> (rd_data_o == '0));

  p_pend_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    ((pend_o & mask_o) == '0));
endmodule

bind irq_mask_bank irqm_checks #(.NUM_SRC(NUM_SRC)) u_checks (
  .clk_i     (clk_i),
  .rst_n     (rst_sync_n),
  .set_we_i  (set_we_i),
  .set_cmd_i (set_cmd_i),
  .clr_we_i  (clr_we_i),
  .clr_cmd_i (clr_cmd_i),
  .word_we_i (word_we_i),
  .rd_addr_i (rd_addr_i),
  .rd_data_o (rd_data_o),
  .mask_o    (mask_o),
  .pend_o    (pend_o)
);

// File: tb/tb_irq_mask_bank.sv
module tb_irq_mask_bank;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  typedef struct packed {
    logic        word_we;
    logic [63:0] wdata;
    logic        set_we;
    logic [7:0]  set_cmd;
    logic        clr_we;
    logic [7:0]  clr_cmd;
    logic [63:0] req;
    logic [63:0] exp_mask;
    logic [63:0] exp_pend;
    logic [7:0]  rq;
  } vec_t;

  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;
  localparam vec_t VEC [NV] = '{
    // R5 clear-all
    '{1'b0, 64'h0, 1'b0, 8'h00, 1'b1, 8'h40, ONES, 64'h0, ONES, 8'd5},
    // R2 set index 5
    '{1'b0, 64'h0, 1'b1, 8'h05, 1'b0, 8'h00, ONES, 64'h20, 64'hFFFF_FFFF_FFFF_FFDF, 8'd2},
    // R2 set index 63
    '{1'b0, 64'h0, 1'b1, 8'h3F, 1'b0, 8'h00, ONES, 64'h8000_0000_0000_0020, 64'h7FFF_FFFF_FFFF_FFDF, 8'd2},
    // R4 clear index 5
    '{1'b0, 64'h0, 1'b0, 8'h00, 1'b1, 8'h05, 64'hFF, 64'h8000_0000_0000_0000, 64'hFF, 8'd4},
    // R10 reserved bit 7 on a set of index 1
    '{1'b0, 64'h0, 1'b1, 8'h81, 1'b0, 8'h00, 64'hFF, 64'h8000_0000_0000_0002, 64'hFD, 8'd10},
    // R3 set-all ignores index 10
    '{1'b0, 64'h0, 1'b1, 8'h4A, 1'b0, 8'h00, 64'hFF, ONES, 64'h0, 8'd3},
    // R10 reserved bit 7 on a clear-all
    '{1'b0, 64'h0, 1'b0, 8'h00, 1'b1, 8'hC0, 64'hFF, 64'h0, 64'hFF, 8'd10},
    // R9 full word write
    '{1'b1, 64'h0000_FFFF_0000_FFFF, 1'b0, 8'h00, 1'b0, 8'h00, ONES, 64'h0000_FFFF_0000_FFFF, 64'hFFFF_0000_FFFF_0000, 8'd9},
    // R6 set and clear of bit 20 together
    '{1'b0, 64'h0, 1'b1, 8'h14, 1'b1, 8'h14, ONES, 64'h0000_FFFF_0010_FFFF, 64'hFFFF_0000_FFEF_0000, 8'd6},
    // R6 set-all and clear-all together
    '{1'b0, 64'h0, 1'b1, 8'h40, 1'b1, 8'h40, ONES, ONES, 64'h0, 8'd6},
    // R9 word write of zero plus set index 0
    '{1'b1, 64'h0, 1'b1, 8'h00, 1'b0, 8'h00, ONES, 64'h1, 64'hFFFF_FFFF_FFFF_FFFE, 8'd9},
    // R11 idle, requests change
    '{1'b0, 64'h0, 1'b0, 8'h00, 1'b0, 8'h00, 64'hAAAA_AAAA_AAAA_AAAA, 64'h1, 64'hAAAA_AAAA_AAAA_AAAA, 8'd11},
    // R9 word write of ones plus clear index 0
    '{1'b1, ONES, 1'b0, 8'h00, 1'b1, 8'h00, ONES, 64'hFFFF_FFFF_FFFF_FFFE, 64'h1, 8'd9}
  };

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        set_we, clr_we, word_we;
  logic [7:0]  set_cmd, clr_cmd;
  logic [63:0] wdata, req, rd_data, mask, pend;
  logic [1:0]  rd_addr;
  int          checks = 0;
  int          fails = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_mask_bank dut (
    .clk_i        (clk),
    .rst_ni       (rst_ni),
    .set_we_i     (set_we),
    .set_cmd_i    (set_cmd),
    .clr_we_i     (clr_we),
    .clr_cmd_i    (clr_cmd),
    .word_we_i    (word_we),
    .word_wdata_i (wdata),
    .rd_addr_i    (rd_addr),
    .rd_data_o    (rd_data),
    .irq_req_i    (req),
    .mask_o       (mask),
    .pend_o       (pend)
  );

  task automatic check(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic idle();
    set_we = 1'b0; clr_we = 1'b0; word_we = 1'b0;
    set_cmd = 8'h00; clr_cmd = 8'h00; wdata = 64'h0;
  endtask

  initial begin
    rst_ni = 1'b0; idle(); req = ONES; rd_addr = 2'd0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 mask", mask, ONES);
    check("R1 pend", pend, 64'h0);
    rd_addr = 2'd1; #1 check("R1 set cmd read", rd_data, 64'h0);
    rd_addr = 2'd2; #1 check("R1 clr cmd read", rd_data, 64'h0);
    rd_addr = 2'd0;

    for (int i = 0; i < NV; i++) begin
      word_we = VEC[i].word_we; wdata = VEC[i].wdata;
      set_we = VEC[i].set_we; set_cmd = VEC[i].set_cmd;
      clr_we = VEC[i].clr_we; clr_cmd = VEC[i].clr_cmd;
      req = VEC[i].req;
      @(negedge clk);
      idle();
      #1;
      check($sformatf("R%0d vec%0d mask", VEC[i].rq, i), rd_data, VEC[i].exp_mask);
      check($sformatf("R%0d vec%0d pend", VEC[i].rq, i), pend, VEC[i].exp_pend);
    end

    // R7 read map after activity
    rd_addr = 2'd3; #1 check("R7 pend read", rd_data, pend);
    set_we = 1'b1; set_cmd = 8'h07; clr_we = 1'b1; clr_cmd = 8'h40;
    rd_addr = 2'd1; #1 check("R7 set cmd read", rd_data, 64'h0);
    rd_addr = 2'd2; #1 check("R7 clr cmd read", rd_data, 64'h0);
    rd_addr = 2'd0;
    @(negedge clk); idle();
    // clear-all then set index 7: R6 and R5 combined
    check("R6 mask", mask, 64'h80);

    // R8 pending changes only after the edge
    req = ONES;
    #1 check("R8 pend before", pend, ~64'h80);
    set_we = 1'b1; set_cmd = 8'h40;
    #1 check("R8 pend still old", pend, ~64'h80);
    @(negedge clk); idle();
    check("R8 pend after edge", pend, 64'h0);

    // R11 hold across several idle cycles
    repeat (4) @(negedge clk);
    check("R11 mask held", mask, ONES);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule